// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block sits between a host and one 8-bit asynchronous NAND flash device. It runs three operations: page read, page program and block erase. The host gives an operation code, a row address (the page number; for erase, the block number), a starting column, a byte count and, for program, a byte stream. The block then produces the command and address cycles on the flash bus. It uses the two-phase framing of large-page parts: an opening command, the address bytes, then a closing command. It waits for the device to signal ready, then moves the data or polls status.

Every flash bus cycle has the same shape. The strobe is held low for a parameterised number of clocks, then high for the same number, so the pulse-width limits of the device are met. Command-latch and address-latch stay valid through the high half, where the device latches the byte.

For program and erase, the block issues the status command once after ready. It then reads status bytes until the ready bit is set, and takes pass or fail from bit 0 of that final byte. A timeout on the ready wait ends the operation with an error. A program can also move the write column inside the page before its data.

Top module: `nand_seq`

## Requirements
- R1: A read (op code 0) emits command 0x00, column low byte, column high byte, row bytes 7:0, 15:8 and 23:16, then command 0x30. After ready it makes req_len read strobes, and each byte read appears on rd_data with a one-cycle rd_valid pulse, in order.
- R2: A program (op code 1) emits command 0x80, the same five address bytes as R1, the req_len data bytes in stream order (one wr_take pulse per byte), then command 0x10.
- R3: An erase (op code 2) of block B emits command 0x60, then three address bytes: (B·64) mod 256, (B/4) mod 256 and (B/1024) mod 256. It then emits command 0xD0.
- R4: After the closing command of a program or erase and after ready, the block emits command 0x70 exactly once. It then keeps reading status bytes until one has bit 6 set.
- R5: When a program or erase completes, fail equals bit 0 of the status byte that had bit 6 set. Bytes read before it do not affect fail. fail is valid from the done pulse until the next accepted request.
- R6: A program with req_move set inserts command 0x85 and the two bytes of req_move_col (low first) after the row bytes and before the data.
- R7: Every write-enable or read-enable low pulse lasts STROBE_CYC clocks, and the two are never low together. Command-latch is high only on command cycles and address-latch only on address cycles, never both.
- R8: Chip enable is low exactly while busy is high. busy rises on the clock edge that accepts a request. done is a single-cycle pulse on the cycle busy falls.
- R9: A request while busy is ignored, and so is a request with op code 3. Neither produces bus activity nor raises busy.
- R10: No read strobe occurs while the ready/busy line shows busy. Polling of that line starts WB_CYC clocks after the closing command cycle ends.
- R11: If the ready/busy line stays low for TIMEOUT_CYC polled clocks, the operation ends with done, tmo=1 and fail=1, and no status command is issued.
- R12: After reset: chip enable, write enable and read enable high; command-latch, address-latch, busy and done low.
- R13: A zero-length program sends the closing command straight after the address bytes. A zero-length read ends after ready with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 no operation |
| req_row | input | 24 | Page number, or block number for erase |
| req_col | input | 16 | Starting column for read or program |
| req_len | input | LEN_W | Byte count for read or program |
| req_move | input | 1 | Program only: move the column before data |
| req_move_col | input | 16 | Column used when req_move is set |
| wr_data | input | 8 | Current program byte from the host stream |
| wr_take | output | 1 | wr_data is consumed at this clock edge |
| rd_data | output | 8 | Last byte read from the flash |
| rd_valid | output | 1 | rd_data holds a new page byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Operation failed (status bit 0 or timeout) |
| tmo | output | 1 | Ready wait timed out |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Flash command latch enable |
| nf_ale | output | 1 | Flash address latch enable |
| nf_we_n | output | 1 | Flash write enable, active low |
| nf_re_n | output | 1 | Flash read enable, active low |
| nf_dq_out | output | 8 | Byte driven onto the flash data bus |
| nf_dq_oe | output | 1 | Drive enable for nf_dq_out |
| nf_dq_in | input | 8 | Byte on the flash data bus |
| nf_rb | input | 1 | Flash ready (1) or busy (0) |

## Verification
A wrong phase or address index shows up on the flash bus at the next latched byte: a missing, extra or misplaced command or address byte appears within one bus cycle of the fault. A miscounted byte counter shows as a wrong number of data strobes before the closing command, or as early or late completion. A wrong status decision shows at the done pulse, as the fail or tmo value or as a status poll that ends on the wrong byte. Errors in strobe timing or chip enable show on the very clock they occur, because the bus shape and the chip enable are compared on every clock.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int COL_W = 16;
  localparam int ROW_W = 24;

  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_WR   = 2'd2,
    CYC_RD   = 2'd3
  } cyc_kind_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_NONE  = 2'd3
  } nand_op_t;

  localparam logic [7:0] CMD_RD_OPEN  = 8'h00;
  localparam logic [7:0] CMD_RD_CLOSE = 8'h30;
  localparam logic [7:0] CMD_PG_OPEN  = 8'h80;
  localparam logic [7:0] CMD_PG_CLOSE = 8'h10;
  localparam logic [7:0] CMD_ER_OPEN  = 8'h60;
  localparam logic [7:0] CMD_ER_CLOSE = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_MOVE     = 8'h85;

  function automatic logic [7:0] open_cmd(nand_op_t op);
    case (op)
      OP_PROG:  return CMD_PG_OPEN;
      OP_ERASE: return CMD_ER_OPEN;
      default:  return CMD_RD_OPEN;
    endcase
  endfunction

  function automatic logic [7:0] close_cmd(nand_op_t op);
    case (op)
      OP_PROG:  return CMD_PG_CLOSE;
      OP_ERASE: return CMD_ER_CLOSE;
      default:  return CMD_RD_CLOSE;
    endcase
  endfunction

  // number of address cycles after the opening command
  function automatic logic [2:0] addr_cycles(nand_op_t op);
    return (op == OP_ERASE) ? 3'd3 : 3'd5;
  endfunction

  // address byte idx of an operation
  function automatic logic [7:0] addr_byte(nand_op_t op, logic [2:0] idx,
                                           logic [COL_W-1:0] col, logic [ROW_W-1:0] row);
    logic [31:0] blk;
    blk = {{(32-ROW_W){1'b0}}, row};
    if (op == OP_ERASE) begin
      case (idx)
        3'd0:    return 8'((blk << 6) & 32'hFF);
        3'd1:    return 8'((blk >> 2) & 32'hFF);
        default: return 8'((blk >> 10) & 32'hFF);
      endcase
    end
    case (idx)
      3'd0:    return col[7:0];
      3'd1:    return col[15:8];
      3'd2:    return row[7:0];
      3'd3:    return row[15:8];
      default: return row[23:16];
    endcase
  endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_seq_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  cyc_kind_t kind,
  input  logic [7:0] byte_in,
  input  logic [7:0] dq_in,
  output logic      active,
  output logic      fin,
  output logic [7:0] rbyte,
  output logic      we_n,
  output logic      re_n,
  output logic      cle,
  output logic      ale,
  output logic [7:0] dq_out,
  output logic      dq_oe
);
  localparam int CW = $clog2(2 * STROBE_CYC + 1);
  localparam logic [CW-1:0] LOW_END = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] LAST    = CW'(2 * STROBE_CYC - 1);
  localparam logic [CW-1:0] HALF    = CW'(STROBE_CYC);

  logic [CW-1:0] cnt;
  cyc_kind_t     kind_q;
  logic [7:0]    byte_q;
  logic          low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      kind_q <= CYC_CMD;
      byte_q <= '0;
      rbyte  <= '0;
    end else if (!active) begin
      if (go) begin
        active <= 1'b1;
        cnt    <= '0;
        kind_q <= kind;
        byte_q <= byte_in;
      end
    end else begin
      if (kind_q == CYC_RD && cnt == LOW_END) rbyte <= dq_in;
      if (cnt == LAST) active <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign low    = active && (cnt < HALF);
  assign fin    = active && (cnt == LAST);
  assign we_n   = !(low && kind_q != CYC_RD);
  assign re_n   = !(low && kind_q == CYC_RD);
  assign cle    = active && kind_q == CYC_CMD;
  assign ale    = active && kind_q == CYC_ADDR;
  assign dq_oe  = active && kind_q != CYC_RD;
  assign dq_out = byte_q;
endmodule

// File: rtl/nand_ready_wait.sv
module nand_ready_wait #(
  parameter int WB_CYC      = 4,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rb,
  output logic waiting,
  output logic ok,
  output logic expired
);
  localparam int MAXC = (WB_CYC > TIMEOUT_CYC) ? WB_CYC : TIMEOUT_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] WB_LAST = TW'(WB_CYC - 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_CYC - 1);

  typedef enum logic [1:0] {W_IDLE, W_SETTLE, W_POLL} wst_t;
  wst_t st;
  logic [TW-1:0] cnt;

  assign waiting = (st != W_IDLE);
  assign ok      = (st == W_POLL) && rb;
  assign expired = (st == W_POLL) && !rb && (cnt == TO_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= W_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          st  <= W_SETTLE;
          cnt <= '0;
        end
        W_SETTLE: if (cnt == WB_LAST) begin
          st  <= W_POLL;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: if (ok || expired) st <= W_IDLE;
                 else cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int STROBE_CYC  = 2,
  parameter int WB_CYC      = 4,
  parameter int TIMEOUT_CYC = 2000,
  parameter int LEN_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [23:0]      req_row,
  input  logic [15:0]      req_col,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_move,
  input  logic [15:0]      req_move_col,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             tmo,
  output logic             nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dq_out,
  output logic             nf_dq_oe,
  input  logic [7:0]       nf_dq_in,
  input  logic             nf_rb
);
  typedef enum logic [3:0] {
    PH_IDLE, PH_OPEN, PH_ADDR, PH_MOVE_CMD, PH_MOVE_ADDR, PH_WDATA,
    PH_CLOSE, PH_WAIT, PH_RDATA, PH_STCMD, PH_STREAD, PH_END
  } phase_t;

  phase_t           ph;
  nand_op_t         op_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] mcol_q;
  logic [LEN_W-1:0] len_q;
  logic             move_q;
  logic [2:0]       aidx;
  logic             fail_q, tmo_q;

  // named internal events
  logic      bus_phase, eng_go, eng_active, eng_fin;
  cyc_kind_t eng_kind;
  logic [7:0] eng_byte, eng_rbyte;
  logic      wait_start, wait_active, wait_ok, wait_expired;
  logic      accept, addr_last, len_one;

  always_comb begin
    bus_phase = 1'b1;
    eng_kind  = CYC_CMD;
    eng_byte  = 8'h00;
    case (ph)
      PH_OPEN:      eng_byte = open_cmd(op_q);
      PH_ADDR:      begin eng_kind = CYC_ADDR; eng_byte = addr_byte(op_q, aidx, col_q, row_q); end
      PH_MOVE_CMD:  eng_byte = CMD_MOVE;
      PH_MOVE_ADDR: begin eng_kind = CYC_ADDR; eng_byte = aidx[0] ? mcol_q[15:8] : mcol_q[7:0]; end
      PH_WDATA:     begin eng_kind = CYC_WR; eng_byte = wr_data; end
      PH_CLOSE:     eng_byte = close_cmd(op_q);
      PH_RDATA:     eng_kind = CYC_RD;
      PH_STCMD:     eng_byte = CMD_STATUS;
      PH_STREAD:    eng_kind = CYC_RD;
      default:      bus_phase = 1'b0;
    endcase
  end

  assign eng_go     = bus_phase && !eng_active;
  assign wr_take    = eng_go && (ph == PH_WDATA);
  assign rd_valid   = eng_fin && (ph == PH_RDATA);
  assign rd_data    = eng_rbyte;
  assign wait_start = eng_fin && (ph == PH_CLOSE);
  assign accept     = (ph == PH_IDLE) && req_valid && (nand_op_t'(req_op) != OP_NONE);
  assign addr_last  = (aidx == addr_cycles(op_q) - 3'd1);
  assign len_one    = (len_q == LEN_W'(1));

  assign busy    = (ph != PH_IDLE) && (ph != PH_END);
  assign done    = (ph == PH_END);
  assign nf_ce_n = !busy;
  assign fail    = fail_q;
  assign tmo     = tmo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      op_q   <= OP_READ;
      row_q  <= '0;
      col_q  <= '0;
      mcol_q <= '0;
      len_q  <= '0;
      move_q <= 1'b0;
      aidx   <= '0;
      fail_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (accept) begin
          op_q   <= nand_op_t'(req_op);
          row_q  <= req_row;
          col_q  <= req_col;
          mcol_q <= req_move_col;
          len_q  <= req_len;
          move_q <= req_move && (nand_op_t'(req_op) == OP_PROG);
          fail_q <= 1'b0;
          tmo_q  <= 1'b0;
          ph     <= PH_OPEN;
        end
        PH_OPEN: if (eng_fin) begin
          aidx <= '0;
          ph   <= PH_ADDR;
        end
        PH_ADDR: if (eng_fin) begin
          if (!addr_last) aidx <= aidx + 3'd1;
          else if (op_q != OP_PROG) ph <= PH_CLOSE;
          else if (move_q) ph <= PH_MOVE_CMD;
          else ph <= (len_q == '0) ? PH_CLOSE : PH_WDATA;
        end
        PH_MOVE_CMD: if (eng_fin) begin
          aidx <= '0;
          ph   <= PH_MOVE_ADDR;
        end
        PH_MOVE_ADDR: if (eng_fin) begin
          if (!aidx[0]) aidx <= 3'd1;
          else ph <= (len_q == '0) ? PH_CLOSE : PH_WDATA;
        end
        PH_WDATA: if (eng_fin) begin
          len_q <= len_q - 1'b1;
          if (len_one) ph <= PH_CLOSE;
        end
        PH_CLOSE: if (eng_fin) ph <= PH_WAIT;
        PH_WAIT: begin
          if (wait_expired) begin
            tmo_q  <= 1'b1;
            fail_q <= 1'b1;
            ph     <= PH_END;
          end else if (wait_ok) begin
            if (op_q != OP_READ) ph <= PH_STCMD;
            else ph <= (len_q == '0) ? PH_END : PH_RDATA;
          end
        end
        PH_RDATA: if (eng_fin) begin
          len_q <= len_q - 1'b1;
          if (len_one) ph <= PH_END;
        end
        PH_STCMD: if (eng_fin) ph <= PH_STREAD;
        PH_STREAD: if (eng_fin && eng_rbyte[6]) begin
          fail_q <= eng_rbyte[0];
          ph     <= PH_END;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  nand_bus_cycle #(.STROBE_CYC(STROBE_CYC)) u_cyc (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .kind(eng_kind), .byte_in(eng_byte),
    .dq_in(nf_dq_in), .active(eng_active), .fin(eng_fin), .rbyte(eng_rbyte),
    .we_n(nf_we_n), .re_n(nf_re_n), .cle(nf_cle), .ale(nf_ale),
    .dq_out(nf_dq_out), .dq_oe(nf_dq_oe)
  );

  nand_ready_wait #(.WB_CYC(WB_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .start(wait_start), .rb(nf_rb),
    .waiting(wait_active), .ok(wait_ok), .expired(wait_expired)
  );
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nf_ce_n,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       busy,
  input logic       done,
  input logic       fail,
  input logic       tmo,
  input logic       wait_active,
  input logic       wait_expired,
  input logic [1:0] op_hold
);
  // R7
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nf_we_n || nf_re_n);

  // R8
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);

  // R9
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_hold));

  // R10
  no_strobe_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_active |-> (nf_re_n && nf_we_n));

  // R11
  expire_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_expired |=> (done && tmo && fail));
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
  .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .busy(busy), .done(done), .fail(fail),
  .tmo(tmo), .wait_active(wait_active), .wait_expired(wait_expired), .op_hold(op_q)
);

// File: tb/tb_nand_seq.sv
`timescale 1ns/1ps
module tb_nand_seq;
  localparam int S   = 2;
  localparam int WB  = 4;
  localparam int TO  = 300;
  localparam int LW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [23:0] req_row = '0;
  logic [15:0] req_col = '0;
  logic [LW-1:0] req_len = '0;
  logic req_move = 1'b0;
  logic [15:0] req_move_col = '0;
  logic [7:0] wr_data;
  logic wr_take, rd_valid, busy, done, fail, tmo;
  logic [7:0] rd_data;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0] nf_dq_out;
  logic [7:0] nf_dq_in = 8'h00;
  logic nf_rb = 1'b1;

  always #2.5 clk = ~clk;

  nand_seq #(.STROBE_CYC(S), .WB_CYC(WB), .TIMEOUT_CYC(TO), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_row(req_row),
    .req_col(req_col), .req_len(req_len), .req_move(req_move), .req_move_col(req_move_col),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .fail(fail), .tmo(tmo), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
    .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out),
    .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rb(nf_rb)
  );

  // ---------------- host write stream ----------------
  logic [7:0] wr_idx = 8'd0;
  function automatic logic [7:0] wpat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  assign wr_data = wpat(int'(wr_idx));
  always @(posedge clk) if (wr_take) wr_idx <= wr_idx + 8'd1;

  // ---------------- expected bus events (written by the flow only) ----------------
  int exp_k [0:511];   // 0 cmd, 1 addr, 2 write data, 3 read strobe
  int exp_b [0:511];
  int exp_n;
  int busy_len;        // clocks of flash busy after a closing command
  int st_busy_n;       // status bytes read with bit 6 clear
  bit st_fail;
  int seed;
  bit model_clr = 1'b0;

  function automatic logic [7:0] ppat(int i, int sd);
    return 8'((i * 13 + sd) & 255);
  endfunction

  // ---------------- flash model and per-clock monitor ----------------
  int exp_ptr, pg_idx, st_idx, rd_idx, busy_cnt, we_run, re_run;
  logic [7:0] last_cmd;
  bit prev_we = 1'b1, prev_re = 1'b1, prev_busy = 1'b0;
  int mon_n = 0, mon_f = 0;

  always @(negedge clk) begin
    int k;
    logic [7:0] sb;
    if (model_clr) begin
      exp_ptr = 0; pg_idx = 0; st_idx = 0; rd_idx = 0; busy_cnt = 0;
      we_run = 0; re_run = 0; last_cmd = 8'h00;
    end
    if (rst_n) begin
      // R8: chip enable tracks busy on every clock
      mon_n++;
      if (nf_ce_n != !busy) begin
        mon_f++; $display("FAIL R8 ce_n vs busy: actual %0d expected %0d", nf_ce_n, !busy);
      end
      if (done) begin
        mon_n++;
        if (!prev_busy || busy) begin
          mon_f++; $display("FAIL R8 done without busy fall: actual %0d expected 1", prev_busy);
        end
      end
      // write strobe rising: byte latched by the flash
      if (!prev_we && nf_we_n) begin
        k = nf_cle ? 0 : (nf_ale ? 1 : 2);
        mon_n++;
        if (we_run != S) begin
          mon_f++; $display("FAIL R7 we_n low width: actual %0d expected %0d", we_run, S);
        end
        mon_n++;
        if (exp_ptr >= exp_n) begin
          mon_f++; $display("FAIL R1/R2/R3 extra bus event: actual %0d/%0h expected none", k, nf_dq_out);
        end else if (exp_k[exp_ptr] != k || exp_b[exp_ptr] != int'(nf_dq_out)) begin
          mon_f++;
          $display("FAIL R1/R2/R3/R6 event %0d: actual %0d/%0h expected %0d/%0h",
                   exp_ptr, k, nf_dq_out, exp_k[exp_ptr], exp_b[exp_ptr]);
        end
        exp_ptr++;
        if (nf_cle) begin
          last_cmd = nf_dq_out;
          if (nf_dq_out == 8'h30 || nf_dq_out == 8'h10 || nf_dq_out == 8'hD0) busy_cnt = busy_len;
        end
        we_run = 0;
      end
      if (!prev_re && nf_re_n) begin
        mon_n++;
        if (re_run != S) begin
          mon_f++; $display("FAIL R7 re_n low width: actual %0d expected %0d", re_run, S);
        end
        mon_n++;
        if (exp_ptr >= exp_n || exp_k[exp_ptr] != 3) begin
          mon_f++; $display("FAIL R1/R4 unexpected read strobe: actual 3 expected %0d",
                            (exp_ptr >= exp_n) ? -1 : exp_k[exp_ptr]);
        end
        exp_ptr++;
        if (last_cmd == 8'h70) st_idx++; else pg_idx++;
        re_run = 0;
      end
      if (!nf_we_n) we_run++;
      if (!nf_re_n) begin
        re_run++;
        // R10: never read while the device is busy
        mon_n++;
        if (busy_cnt != 0) begin
          mon_f++; $display("FAIL R10 read while busy: actual %0d expected 0", busy_cnt);
        end
        if (last_cmd == 8'h70) begin
          sb = (st_idx < st_busy_n) ? {7'b0, !st_fail} : {7'b0100000, st_fail};
          nf_dq_in = sb;
        end else nf_dq_in = ppat(pg_idx, seed);
      end
      if (rd_valid) begin
        mon_n++;
        if (rd_data != ppat(rd_idx, seed)) begin
          mon_f++; $display("FAIL R1 read byte %0d: actual %0h expected %0h", rd_idx, rd_data, ppat(rd_idx, seed));
        end
        rd_idx++;
      end
    end
    prev_we = nf_we_n; prev_re = nf_re_n; prev_busy = busy;
    if (busy_cnt > 0) busy_cnt--;
    nf_rb = (busy_cnt == 0);
  end

  // ---------------- flow checks ----------------
  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++; $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int k, input int b);
    exp_k[exp_n] = k; exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic clear_model();
    @(negedge clk); model_clr = 1'b1;
    @(negedge clk); model_clr = 1'b0;
  endtask

  // builds the expected event list and runs one operation to done
  task automatic run_op(input int op, input int row, input int col, input int len,
                        input bit mv, input int mcol, input bit timeout_case,
                        input bit exp_fail, input string req);
    int wbase, cyc;
    bit seen;
    clear_model();
    exp_n = 0;
    wbase = int'(wr_idx);
    if (op == 2) begin
      push(0, 'h60);
      push(1, (row * 64) % 256); push(1, (row / 4) % 256); push(1, (row / 1024) % 256);
      push(0, 'hD0);
    end else begin
      push(0, (op == 0) ? 'h00 : 'h80);
      push(1, col % 256); push(1, (col / 256) % 256);
      push(1, row % 256); push(1, (row / 256) % 256); push(1, (row / 65536) % 256);
      if (op == 1 && mv) begin
        push(0, 'h85); push(1, mcol % 256); push(1, (mcol / 256) % 256);
      end
      if (op == 1) for (int i = 0; i < len; i++) push(2, int'(wpat((wbase + i) % 256)));
      push(0, (op == 0) ? 'h30 : 'h10);
    end
    if (!timeout_case) begin
      if (op == 0) for (int i = 0; i < len; i++) push(3, 0);
      else begin
        push(0, 'h70);
        for (int i = 0; i <= st_busy_n; i++) push(3, 0);
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_row = 24'(row); req_col = 16'(col);
    req_len = LW'(len); req_move = mv; req_move_col = 16'(mcol);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
    seen = 1'b0;
    for (cyc = 0; cyc < 8000 && !seen; cyc++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, req, "done reached", seen, 1);
    chk(fail == exp_fail, (op == 0) ? "R1" : "R5", "fail flag", fail, exp_fail);
    chk(tmo == timeout_case, "R11", "tmo flag", tmo, timeout_case);
    @(negedge clk);
    chk(exp_ptr == exp_n, req, "bus events consumed", exp_ptr, exp_n);
    if (op == 0) chk(rd_idx == len, "R1", "rd_valid count", rd_idx, len);
    if (op == 1) chk(int'(wr_idx) == (wbase + len) % 256, "R2", "bytes taken", int'(wr_idx), (wbase + len) % 256);
  endtask

  task automatic run_all();
    busy_len = 20; st_busy_n = 0; st_fail = 1'b0; seed = 5;
    repeat (4) @(negedge clk);
    // R12: reset values
    chk(nf_ce_n == 1'b1, "R12", "ce_n", nf_ce_n, 1);
    chk(nf_we_n == 1'b1 && nf_re_n == 1'b1, "R12", "we_n/re_n", {nf_we_n, nf_re_n}, 3);
    chk(nf_cle == 1'b0 && nf_ale == 1'b0, "R12", "cle/ale", {nf_cle, nf_ale}, 0);
    chk(busy == 1'b0 && done == 1'b0, "R12", "busy/done", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(nf_ce_n == 1'b1 && busy == 1'b0, "R12", "idle after reset", {nf_ce_n, busy}, 2);

    // R1, R10: page reads
    seed = 5;  run_op(0, 'h012345, 'h0000, 8, 0, 0, 0, 0, "R1");
    seed = 90; run_op(0, 'h00ABCD, 'h0802, 3, 0, 0, 0, 0, "R1");
    // R2, R4, R5: program with status polling and pass
    st_busy_n = 2; st_fail = 1'b0;
    run_op(1, 'h000140, 'h0000, 6, 0, 0, 0, 0, "R2");
    // R6, R5: program with column move, final status fails
    st_busy_n = 1; st_fail = 1'b1;
    run_op(1, 'h000141, 'h0000, 4, 1, 'h0800, 0, 1, "R6");
    // R3: erase pass and fail
    st_busy_n = 0; st_fail = 1'b0;
    run_op(2, 'h0007FF, 0, 0, 0, 0, 0, 0, "R3");
    st_busy_n = 3; st_fail = 1'b1;
    run_op(2, 'h000ABC, 0, 0, 0, 0, 0, 1, "R3");
    // R13: zero-length program and read
    st_busy_n = 0; st_fail = 1'b0;
    run_op(1, 'h000200, 'h0010, 0, 0, 0, 0, 0, "R13");
    run_op(0, 'h000201, 'h0000, 0, 0, 0, 0, 0, "R13");
    // R11: ready never returns within the timeout
    busy_len = TO + 400;
    run_op(2, 'h000033, 0, 0, 0, 0, 1, 1, "R11");
    while (!nf_rb) @(negedge clk);
    busy_len = 20;
    // R9: request while busy is ignored
    st_busy_n = 1; st_fail = 1'b0;
    fork
      run_op(1, 'h000300, 'h0000, 5, 0, 0, 0, 0, "R9");
      begin
        repeat (12) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_row = 24'h000777;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (6) @(negedge clk);
    chk(busy == 1'b0 && nf_ce_n == 1'b1, "R9", "no operation after busy request", busy, 0);
    // R9: op code 3 is ignored
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b0, "R9", "op 3 not accepted", busy, 0);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && nf_we_n == 1'b1 && nf_re_n == 1'b1, "R9", "op 3 no bus activity",
        {busy, nf_we_n, nf_re_n}, 3);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual expired expected completion");
    end
    n_chk += mon_n;
    n_fail += mon_f;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule